// File: doc/BRIEF.md
# Reset and Watchdog Supervisor

This block produces the chip-wide reset and the low-power wake event for a small USB device controller. Three things can cause a reset. The first is a power-on one-shot that runs while supply status is good. The second is a watchdog that counts ticks of an internal RC oscillator. The third is a strobe from the USB serial engine, raised when the host signals a bus reset. The chip reset output is the OR of the power-on hold and a fixed-length reset pulse. The pulse is started by a watchdog expiry in run mode or by a USB host reset.

While the device is in stop or suspend, a watchdog expiry does not reset the chip. It produces a single-cycle wake pulse instead, so a device whose oscillator stays enabled wakes periodically. A USB host reset still resets the chip in stop or suspend. When the device recovers from stop mode, a recovery strobe cuts the power-on hold short. A three-bit cause register records why the chip was reset, and firmware clears it one bit at a time by writing ones.

Top module: `rst_wdt_supervisor`

## Requirements
- R1: While rst_ni is low, chip_rst_o is 1, wake_o is 0 and rst_src_o is 3'b001 (bit 0 = power, bit 1 = watchdog, bit 2 = USB host).
- R2: Once pwr_good_i has been high for POR_TICKS consecutive clock edges, chip_rst_o falls. It is still 1 after POR_TICKS-1 of those edges.
- R3: A low level on pwr_good_i at any clock edge re-arms the power-on timer. chip_rst_o is 1 after that edge, rst_src_o bit 0 is set, and a full POR_TICKS period is needed after pwr_good_i returns.
- R4: A stop_recover_i pulse while the power-on timer runs with pwr_good_i high ends the hold, and chip_rst_o is 0 after that edge.
- R5: With rc_en_i high and low_power_i low, the watchdog times out on the Nth rc_tick_i since the last clear, where N = WDT_BASE << wdt_sel. chip_rst_o is 1 from the second edge after that tick for exactly RST_PULSE cycles, and rst_src_o bit 1 is set.
- R6: A wdt_kick_i pulse clears the watchdog count to zero, so a full N further ticks are needed for a timeout.
- R7: wdt_sel_we_i loads wdt_sel_i at any time, including while counting. If the count already meets or exceeds the new N-1, the next tick times out.
- R8: With low_power_i high, a watchdog timeout gives one cycle of wake_o, starting at the second edge after the final tick. It causes no chip reset and leaves rst_src_o bit 1 clear.
- R9: With rc_en_i low the watchdog does not count, so ticks produce neither wake nor reset.
- R10: A usb_rst_i pulse sets rst_src_o bit 2 and starts the RST_PULSE reset, both visible after the same edge. This holds whether low_power_i is high or low.
- R11: src_clr_i clears the matching rst_src_o bits after one edge. When a bit is set and cleared in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| pwr_good_i | input | 1 | Supply status from the power detector |
| stop_recover_i | input | 1 | Stop-mode recovery strobe; bypasses power-on hold |
| low_power_i | input | 1 | Device is in stop or suspend |
| rc_en_i | input | 1 | RC oscillator enabled |
| rc_tick_i | input | 1 | One-cycle RC oscillator tick |
| wdt_kick_i | input | 1 | Firmware watchdog refresh strobe |
| wdt_sel_we_i | input | 1 | Load strobe for the timeout select |
| wdt_sel_i | input | SEL_W | Timeout select, N = WDT_BASE << value |
| usb_rst_i | input | 1 | Host bus reset detected |
| src_clr_i | input | 3 | Write-one-to-clear mask for the cause bits |
| chip_rst_o | output | 1 | Synchronous chip reset |
| wake_o | output | 1 | One-cycle wake pulse |
| rst_src_o | output | 3 | Latched reset cause |

## Verification
The assertions assume that rc_tick_i, usb_rst_i and stop_recover_i are single-cycle strobes in the clock domain. They also assume that pwr_good_i has already been synchronised, and that low_power_i does not change in the cycle in which a watchdog expiry is being registered. The bench drives every input one full cycle at a time from the falling edge. It separates each tick with an idle cycle and changes low_power_i only while the watchdog is idle or freshly cleared. It samples outputs on the falling edge, which lets every expected edge count in the requirements be checked exactly.

// File: rtl/rsw_pkg.sv
package rsw_pkg;
  localparam int SRC_W   = 3;
  localparam int SRC_PWR = 0;
  localparam int SRC_WDT = 1;
  localparam int SRC_USB = 2;
  typedef logic [SRC_W-1:0] src_t;
  localparam src_t SRC_RST_VAL = src_t'(1) << SRC_PWR;
endpackage

// File: rtl/rsw_por_timer.sv
module rsw_por_timer #(
  parameter int POR_TICKS = 40
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_good_i,
  input  logic stop_recover_i,
  output logic hold_o
);
  localparam int CW = $clog2(POR_TICKS + 1);
  logic [CW-1:0] cnt_q;
  logic          act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= 1'b1;
    end else if (!pwr_good_i) begin
      cnt_q <= '0;
      act_q <= 1'b1;
    end else if (act_q) begin
      if (stop_recover_i || cnt_q == CW'(POR_TICKS - 1)) begin
        act_q <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign hold_o = act_q;

  // power loss re-arms at once
  assert_rearm_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_good_i |=> hold_o);
  // release only with supply good
  assert_release_pwr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hold_o) |-> $past(pwr_good_i));
endmodule

// File: rtl/rsw_wdt.sv
module rsw_wdt #(
  parameter int WDT_BASE = 8,
  parameter int SEL_W    = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             kick_i,
  input  logic             rc_en_i,
  input  logic             tick_i,
  input  logic             sel_we_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             expire_o
);
  localparam int CW = $clog2(WDT_BASE) + (1 << SEL_W) + 1;
  logic [CW-1:0]    cnt_q;
  logic [SEL_W-1:0] sel_q;
  logic [CW-1:0]    limit;
  logic             hit;

  assign limit = CW'(WDT_BASE) << sel_q;
  assign hit   = rc_en_i && tick_i && (cnt_q >= limit - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= '0;
    else if (sel_we_i) sel_q <= sel_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      expire_o <= 1'b0;
    end else if (clear_i || kick_i) begin
      cnt_q    <= '0;
      expire_o <= 1'b0;
    end else begin
      expire_o <= hit;
      if (hit) cnt_q <= '0;
      else if (rc_en_i && tick_i) cnt_q <= cnt_q + 1'b1;
    end
  end

  assert_expire_restart_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |-> cnt_q == '0);
  assert_kick_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_i |=> (cnt_q == '0 && !expire_o));
  assert_osc_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rc_en_i |=> !expire_o);
endmodule

// File: rtl/rsw_src_reg.sv
module rsw_src_reg
  import rsw_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  src_t set_i,
  input  src_t clr_i,
  output src_t src_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) src_o <= SRC_RST_VAL;
    else         src_o <= set_i | (src_o & ~clr_i);
  end

  assert_usb_latched_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i[SRC_USB] |=> src_o[SRC_USB]);
  assert_clear_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i[SRC_WDT] && !set_i[SRC_WDT]) |=> !src_o[SRC_WDT]);
endmodule

// File: rtl/rst_wdt_supervisor.sv
module rst_wdt_supervisor
  import rsw_pkg::*;
#(
  parameter int POR_TICKS = 40,
  parameter int WDT_BASE  = 8,
  parameter int SEL_W     = 2,
  parameter int RST_PULSE = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pwr_good_i,
  input  logic             stop_recover_i,
  input  logic             low_power_i,
  input  logic             rc_en_i,
  input  logic             rc_tick_i,
  input  logic             wdt_kick_i,
  input  logic             wdt_sel_we_i,
  input  logic [SEL_W-1:0] wdt_sel_i,
  input  logic             usb_rst_i,
  input  logic [SRC_W-1:0] src_clr_i,
  output logic             chip_rst_o,
  output logic             wake_o,
  output logic [SRC_W-1:0] rst_src_o
);
  localparam int PW = $clog2(RST_PULSE + 1);

  logic          por_hold, wdt_expire, wdt_rst, pulse_go, pulse_act;
  logic [PW-1:0] pulse_q;
  src_t          src_set;

  rsw_por_timer #(.POR_TICKS(POR_TICKS)) u_por (
    .clk_i, .rst_ni, .pwr_good_i, .stop_recover_i, .hold_o(por_hold)
  );

  rsw_wdt #(.WDT_BASE(WDT_BASE), .SEL_W(SEL_W)) u_wdt (
    .clk_i, .rst_ni,
    .clear_i (chip_rst_o),
    .kick_i  (wdt_kick_i),
    .rc_en_i,
    .tick_i  (rc_tick_i),
    .sel_we_i(wdt_sel_we_i),
    .sel_i   (wdt_sel_i),
    .expire_o(wdt_expire)
  );

  // expiry resets in run mode, wakes in stop/suspend
  assign wdt_rst  = wdt_expire && !low_power_i;
  assign pulse_go = wdt_rst || usb_rst_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pulse_q <= '0;
      wake_o  <= 1'b0;
    end else begin
      wake_o <= wdt_expire && low_power_i;
      if (pulse_go)            pulse_q <= PW'(RST_PULSE);
      else if (pulse_q != '0)  pulse_q <= pulse_q - 1'b1;
    end
  end

  assign pulse_act  = pulse_q != '0;
  assign chip_rst_o = por_hold || pulse_act || !rst_ni;

  always_comb begin
    src_set          = '0;
    src_set[SRC_PWR] = !pwr_good_i;
    src_set[SRC_WDT] = wdt_rst;
    src_set[SRC_USB] = usb_rst_i;
  end

  rsw_src_reg u_src (
    .clk_i, .rst_ni, .set_i(src_set), .clr_i(src_clr_i), .src_o(rst_src_o)
  );

  assert_wake_lowpwr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> $past(low_power_i));
  assert_pulse_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pulse_act) |-> (rst_src_o[SRC_WDT] || rst_src_o[SRC_USB]));
  assert_usb_resets_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    usb_rst_i |=> chip_rst_o);
  assert_wake_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> !wake_o);
endmodule

// File: tb/rst_wdt_supervisor_bench.sv
module rst_wdt_supervisor_bench;
  localparam int P = 40, B = 8, SW = 2, RP = 4;

  logic clk = 0, rst_n = 0;
  logic pwr_good = 0, stop_rec = 0, low_pwr = 0, rc_en = 0, rc_tick = 0;
  logic kick = 0, sel_we = 0, usb_rst = 0;
  logic [SW-1:0] sel = '0;
  logic [2:0] src_clr = '0;
  logic chip_rst, wake;
  logic [2:0] src;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  rst_wdt_supervisor #(.POR_TICKS(P), .WDT_BASE(B), .SEL_W(SW), .RST_PULSE(RP))
  u_rst_wdt_supervisor (
    .clk_i(clk), .rst_ni(rst_n), .pwr_good_i(pwr_good), .stop_recover_i(stop_rec),
    .low_power_i(low_pwr), .rc_en_i(rc_en), .rc_tick_i(rc_tick), .wdt_kick_i(kick),
    .wdt_sel_we_i(sel_we), .wdt_sel_i(sel), .usb_rst_i(usb_rst), .src_clr_i(src_clr),
    .chip_rst_o(chip_rst), .wake_o(wake), .rst_src_o(src)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h @%0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      rc_tick = 1; step(1); rc_tick = 0; step(1);
    end
  endtask

  task automatic clear_src();
    src_clr = 3'b111; step(1); src_clr = 3'b000;
  endtask

  task automatic t_reset();
    step(3);
    chk("R1 chip_rst", chip_rst, 1);
    chk("R1 wake", wake, 0);
    chk("R1 src", src, 3'b001);
    rst_n = 1; step(1);
  endtask

  task automatic t_por();
    pwr_good = 1;
    step(P - 1); chk("R2 hold", chip_rst, 1);
    step(1);     chk("R2 release", chip_rst, 0);
    clear_src(); chk("R11 cleared", src, 3'b000);
    usb_rst = 1; src_clr = 3'b100; step(1); usb_rst = 0; src_clr = 0;
    chk("R11 set wins", src, 3'b100);
    step(RP + 1); clear_src();
  endtask

  task automatic t_rearm();
    pwr_good = 0; step(1);
    chk("R3 rst", chip_rst, 1);
    chk("R3 src pwr", src[0], 1);
    step(3); pwr_good = 1;
    step(P - 1); chk("R3 full hold", chip_rst, 1);
    step(1);     chk("R3 release", chip_rst, 0);
  endtask

  task automatic t_recover();
    pwr_good = 0; step(2); pwr_good = 1; step(5);
    chk("R4 running", chip_rst, 1);
    stop_rec = 1; step(1); stop_rec = 0;
    chk("R4 bypass", chip_rst, 0);
    clear_src();
  endtask

  task automatic t_wdt_timeout();
    sel = 0; sel_we = 1; kick = 1; step(1); sel_we = 0; kick = 0;
    rc_en = 1;
    ticks(B - 1); chk("R5 before N", chip_rst, 0);
    rc_tick = 1; step(1); rc_tick = 0;
    chk("R5 one edge later", chip_rst, 0);
    step(1); chk("R5 rst start", chip_rst, 1);
    chk("R5 src wdt", src[1], 1);
    step(RP - 1); chk("R5 rst last", chip_rst, 1);
    step(1);      chk("R5 rst end", chip_rst, 0);
    clear_src();
  endtask

  task automatic t_kick();
    ticks(B - 2);
    kick = 1; step(1); kick = 0;
    ticks(B - 1); chk("R6 no timeout", chip_rst, 0);
    ticks(1); chk("R6 timeout", chip_rst, 1);
    step(RP + 1); clear_src();
  endtask

  task automatic t_resel();
    sel = 2; sel_we = 1; step(1); sel_we = 0;
    ticks(20); chk("R7 long limit", chip_rst, 0);
    sel = 0; sel_we = 1; step(1); sel_we = 0;
    ticks(1); chk("R7 immediate", chip_rst, 1);
    step(RP + 1); clear_src();
  endtask

  task automatic t_wake();
    int wakes;
    low_pwr = 1; kick = 1; step(1); kick = 0;
    ticks(B - 1); chk("R8 no wake yet", wake, 0);
    rc_tick = 1; step(1); rc_tick = 0; step(1);
    chk("R8 wake", wake, 1);
    chk("R8 no rst", chip_rst, 0);
    step(1); chk("R8 single", wake, 0);
    chk("R8 src wdt clear", src[1], 0);
    wakes = 0;
    for (int i = 0; i < B; i++) begin
      rc_tick = 1; step(1); rc_tick = 0; wakes += wake; step(1); wakes += wake;
    end
    chk("R8 periodic", wakes, 1);
  endtask

  task automatic t_osc_off();
    int ev;
    rc_en = 0; ev = 0;
    for (int i = 0; i < 3 * B; i++) begin
      rc_tick = 1; step(1); rc_tick = 0; ev += wake + chip_rst; step(1); ev += wake + chip_rst;
    end
    chk("R9 no events", ev, 0);
  endtask

  task automatic t_usb();
    usb_rst = 1; step(1); usb_rst = 0;
    chk("R10 rst in low power", chip_rst, 1);
    chk("R10 src usb", src, 3'b100);
    step(RP - 1); chk("R10 last", chip_rst, 1);
    step(1); chk("R10 end", chip_rst, 0);
    low_pwr = 0;
    usb_rst = 1; step(1); usb_rst = 0;
    chk("R10 rst run", chip_rst, 1);
  endtask

  initial begin
    fork
      begin
        t_reset(); t_por(); t_rearm(); t_recover(); t_wdt_timeout();
        t_kick(); t_resel(); t_wake(); t_osc_off(); t_usb();
      end
      begin
        step(20000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule